// File: doc/BRIEF.md
# PCM Transmit Serializer with Frame Sync

This block drives one T1 or E1 link toward a framer. It asks an upstream byte source for payload bytes one at a time and shifts each byte out on a serial data line, most significant bit first. Every byte lands in a timeslot chosen by the configured channel map. Timeslots that carry no payload are filled with all ones. The frame always has 32 slots of 8 bits each, so one bit is sent on each active edge of the transmit bit clock. Only the placement of the payload differs from one map to the next.

The frame sync can work in either of two directions. As an output, the block drives one pulse, one bit wide, during the last bit of every frame. As an input, the first sync the block sees starts the frame counter. From then on, every sync that does not fall on the last bit of the frame, and every frame end that has no sync, is reported.

Clock and sync polarity can each be inverted. A disabled block puts its serial outputs in the high-impedance state and returns to its startup state. The bit clock is sampled in the system clock domain, so it must be much slower than `clk_i`.

Top module: `pcm_tx_serializer`

## Requirements
- R1: In a payload slot, the requested byte is sent MSB first, one bit per active bit-clock edge. The payload slots for each map (slots numbered 0 to 31, map_mode_i value in brackets) are:
  - [0] T1 head map: slots 0 to 23.
  - [1] T1 spread map: every slot whose index is not a multiple of 4.
  - [2] and [3] E1 map: every slot except 0 and 16.
- R2: Every bit of a non-payload slot is 1. The data line is also 1 after reset, until the first payload slot starts.
- R3: When rsv_ts24_i is 1, the 24th T1 channel is idle (all ones). In the head map this is slot 23; in the spread map it is slot 31. In the E1 map rsv_ts24_i has no effect.
- R4: byte_req_o pulses for exactly one clk_i cycle, once for each payload slot. The pulse comes right after the start of the slot before that payload slot. One more pulse comes in the first enabled cycle after reset or enable, when slot 0 is a payload slot. byte_i must hold the requested byte until the next slot boundary.
- R5: With sync_in_mode_i low, tx_sync_o is high for exactly the last bit (slot 31, bit 7) of each frame. When sync_inv_i is 1, the level is inverted.
- R6: The active bit-clock edge is rising when clk_inv_i is 0 and falling when clk_inv_i is 1. Data changes only after an active edge.
- R7: With sync_in_mode_i high, tx_sync_i (after sync_inv_i) is sampled on each active edge. The first high sample starts slot 0. After that, every mismatch gives a one-cycle sync_err_o pulse and the frame keeps counting. A mismatch is a high sample that does not end the last bit, or a low sample that does end it.
- R8: While en_i is low, tx_data_o and tx_sync_o are high-impedance, and no request or error is raised. When en_i goes high again, the block restarts from its reset state, including the startup request of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Unit enable; low gives high-impedance outputs and a restart |
| map_mode_i | input | 2 | Channel map: 0 T1 head, 1 T1 spread, 2/3 E1 |
| rsv_ts24_i | input | 1 | Keep the 24th T1 channel idle |
| sync_in_mode_i | input | 1 | 1: sync is an input and is checked; 0: sync is generated |
| clk_inv_i | input | 1 | Falling edge of the bit clock is the active edge |
| sync_inv_i | input | 1 | Sync is active low |
| tx_clk_i | input | 1 | Transmit bit clock |
| tx_sync_i | input | 1 | Frame sync from the framer (input mode) |
| tx_sync_o | output | 1 | Generated frame sync; high-impedance in input mode |
| tx_data_o | output | 1 | Serial data |
| byte_req_o | output | 1 | One-cycle request for the next payload byte |
| byte_i | input | 8 | Payload byte, held until the next slot boundary |
| sync_err_o | output | 1 | One-cycle pulse on a sync period mismatch |

## Verification
Two things share the same active edge: the load of a new slot byte and the frame-boundary sync decision. In output mode the edge that ends the sync pulse also loads slot 0. In input mode the edge that checks the sync also moves on to slot 0, and on the first sync it also starts the frame. The bench triggers these cases with the T1 head map, where slot 0 carries payload. It also places early extra syncs and drops expected ones at frame ends. An independent frame model predicts each serial bit, each sync level and each error pulse, and every bit period is compared against it.

// File: rtl/pcm_tx_pkg.sv
`timescale 1ns/1ps
package pcm_tx_pkg;
  localparam int unsigned SLOT_BITS   = 8;
  localparam int unsigned FRAME_SLOTS = 32;
  localparam int unsigned T1_CHANNELS = 24;
  localparam int unsigned E1_SIG_SLOT = 16;

  typedef enum logic [1:0] {
    MAP_T1_HEAD   = 2'd0,
    MAP_T1_SPREAD = 2'd1,
    MAP_E1        = 2'd2,
    MAP_E1_ALT    = 2'd3
  } map_mode_e;
endpackage

// File: rtl/pcm_bit_edge.sv
`timescale 1ns/1ps
module pcm_bit_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_clk_i,
  input  logic clk_inv_i,
  input  logic tx_sync_i,
  input  logic sync_inv_i,
  output logic tick_o,
  output logic sync_lvl_o
);
  logic clk_q, clk_qq, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_q  <= 1'b0;
      clk_qq <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      clk_q  <= tx_clk_i ^ clk_inv_i;
      clk_qq <= clk_q;
      sync_q <= tx_sync_i ^ sync_inv_i;
    end
  end

  // sync sampled alongside the clock, so it is aligned with the tick
  assign tick_o     = clk_q & ~clk_qq;
  assign sync_lvl_o = sync_q;
endmodule

// File: rtl/pcm_slot_map.sv
`timescale 1ns/1ps
module pcm_slot_map
  import pcm_tx_pkg::*;
#(
  parameter int unsigned SLOTS = FRAME_SLOTS,
  localparam int unsigned SW   = $clog2(SLOTS)
) (
  input  map_mode_e   mode_i,
  input  logic        reserve_i,
  input  logic [SW-1:0] slot_i,
  output logic        payload_o
);
  logic carry, ts24;

  always_comb begin
    case (mode_i)
      MAP_T1_HEAD: begin
        carry = slot_i < SW'(T1_CHANNELS);
        ts24  = slot_i == SW'(T1_CHANNELS - 1);
      end
      MAP_T1_SPREAD: begin
        carry = slot_i[1:0] != 2'd0;
        ts24  = slot_i == SW'(SLOTS - 1);
      end
      default: begin
        carry = (slot_i != '0) && (slot_i != SW'(E1_SIG_SLOT));
        ts24  = 1'b0;
      end
    endcase
    payload_o = carry && !(reserve_i && ts24);
  end
endmodule

// File: rtl/pcm_frame_timer.sv
`timescale 1ns/1ps
module pcm_frame_timer
  import pcm_tx_pkg::*;
#(
  parameter int unsigned SLOTS = FRAME_SLOTS,
  parameter int unsigned BITS  = SLOT_BITS,
  localparam int unsigned SW   = $clog2(SLOTS),
  localparam int unsigned BW   = $clog2(BITS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic          sync_lvl_i,
  input  logic          sync_in_mode_i,
  output logic          load_o,
  output logic [SW-1:0] load_slot_o,
  output logic          frame_last_o,
  output logic          sync_err_o
);
  localparam logic [SW-1:0] LAST_SLOT = SW'(SLOTS - 1);
  localparam logic [BW-1:0] LAST_BIT  = BW'(BITS - 1);

  logic [SW-1:0] slot_q;
  logic [BW-1:0] bit_q;
  logic          locked_q, err_q;
  logic          at_last_bit, at_frame_end, running, acquire, step;

  assign at_last_bit  = bit_q == LAST_BIT;
  assign at_frame_end = at_last_bit && (slot_q == LAST_SLOT);
  assign running      = !sync_in_mode_i || locked_q;
  assign acquire      = tick_i && sync_in_mode_i && !locked_q && sync_lvl_i;
  assign step         = tick_i && running;

  assign load_o       = en_i && (acquire || (step && at_last_bit));
  assign load_slot_o  = (acquire || at_frame_end) ? '0 : slot_q + SW'(1);
  assign frame_last_o = at_frame_end;
  assign sync_err_o   = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q   <= LAST_SLOT;
      bit_q    <= '0;
      locked_q <= 1'b0;
      err_q    <= 1'b0;
    end else if (!en_i) begin
      slot_q   <= LAST_SLOT;
      bit_q    <= '0;
      locked_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      err_q <= step && sync_in_mode_i && (sync_lvl_i != at_frame_end);
      if (acquire) begin
        locked_q <= 1'b1;
        slot_q   <= '0;
        bit_q    <= '0;
      end else if (step) begin
        if (at_last_bit) begin
          bit_q  <= '0;
          slot_q <= load_slot_o;
        end else begin
          bit_q  <= bit_q + BW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/pcm_shift_out.sv
`timescale 1ns/1ps
module pcm_shift_out #(
  parameter int unsigned BITS = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            tick_i,
  input  logic            load_i,
  input  logic            payload_i,
  input  logic [BITS-1:0] byte_i,
  output logic            bit_o
);
  logic [BITS-1:0] sreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '1;
    end else if (!en_i) begin
      sreg_q <= '1;
    end else if (load_i) begin
      sreg_q <= payload_i ? byte_i : '1;
    end else if (tick_i) begin
      sreg_q <= {sreg_q[BITS-2:0], 1'b1};
    end
  end

  assign bit_o = sreg_q[BITS-1];
endmodule

// File: rtl/pcm_tx_serializer.sv
`timescale 1ns/1ps
module pcm_tx_serializer
  import pcm_tx_pkg::*;
#(
  parameter int unsigned SLOTS = FRAME_SLOTS,
  parameter int unsigned BITS  = SLOT_BITS
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [1:0]      map_mode_i,
  input  logic            rsv_ts24_i,
  input  logic            sync_in_mode_i,
  input  logic            clk_inv_i,
  input  logic            sync_inv_i,
  input  logic            tx_clk_i,
  input  logic            tx_sync_i,
  output logic            tx_sync_o,
  output logic            tx_data_o,
  output logic            byte_req_o,
  input  logic [BITS-1:0] byte_i,
  output logic            sync_err_o
);
  localparam int unsigned SW   = $clog2(SLOTS);
  localparam int unsigned NMAP = 2;   // 0: slot being loaded, 1: slot being requested

  logic          tick, sync_lvl, load, frame_last, shift_bit;
  logic          init_q, req_q;
  logic [SW-1:0] load_slot, req_slot;
  logic [SW-1:0] map_slot [NMAP];
  logic [NMAP-1:0] map_hit;
  map_mode_e     mode;

  assign mode = map_mode_e'(map_mode_i);

  pcm_bit_edge u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tx_clk_i   (tx_clk_i),
    .clk_inv_i  (clk_inv_i),
    .tx_sync_i  (tx_sync_i),
    .sync_inv_i (sync_inv_i),
    .tick_o     (tick),
    .sync_lvl_o (sync_lvl)
  );

  pcm_frame_timer #(.SLOTS(SLOTS), .BITS(BITS)) u_timer (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .en_i           (en_i),
    .tick_i         (tick),
    .sync_lvl_i     (sync_lvl),
    .sync_in_mode_i (sync_in_mode_i),
    .load_o         (load),
    .load_slot_o    (load_slot),
    .frame_last_o   (frame_last),
    .sync_err_o     (sync_err_o)
  );

  // startup stands in the last slot, so its request targets slot 0
  assign req_slot = init_q ? '0
                  : ((load_slot == SW'(SLOTS - 1)) ? '0 : load_slot + SW'(1));
  assign map_slot[0] = load_slot;
  assign map_slot[1] = req_slot;

  for (genvar g = 0; g < NMAP; g++) begin : g_map
    pcm_slot_map #(.SLOTS(SLOTS)) u_map (
      .mode_i    (mode),
      .reserve_i (rsv_ts24_i),
      .slot_i    (map_slot[g]),
      .payload_o (map_hit[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= 1'b1;
      req_q  <= 1'b0;
    end else if (!en_i) begin
      init_q <= 1'b1;
      req_q  <= 1'b0;
    end else begin
      init_q <= 1'b0;
      req_q  <= (init_q || load) && map_hit[1];
    end
  end

  pcm_shift_out #(.BITS(BITS)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .tick_i    (tick),
    .load_i    (load),
    .payload_i (map_hit[0]),
    .byte_i    (byte_i),
    .bit_o     (shift_bit)
  );

  assign byte_req_o = req_q;
  assign tx_data_o  = en_i ? shift_bit : 1'bz;
  assign tx_sync_o  = (en_i && !sync_in_mode_i) ? (frame_last ^ sync_inv_i) : 1'bz;
endmodule

// File: rtl/pcm_tx_serializer_chk.sv
`timescale 1ns/1ps
module pcm_tx_serializer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic sync_in_mode_i,
  input logic byte_req_o,
  input logic sync_err_o,
  input logic frame_last_i
);
  // R4
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_req_o |=> !byte_req_o);

  // R4
  req_slot_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_req_o |-> !frame_last_i);

  // R7
  err_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_err_o |-> $past(sync_in_mode_i));

  // R7
  err_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_err_o |=> !sync_err_o);

  // R8
  off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!byte_req_o && !sync_err_o));
endmodule

bind pcm_tx_serializer pcm_tx_serializer_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .en_i           (en_i),
  .sync_in_mode_i (sync_in_mode_i),
  .byte_req_o     (byte_req_o),
  .sync_err_o     (sync_err_o),
  .frame_last_i   (frame_last)
);

// File: tb/pcm_tx_serializer_tb.sv
`timescale 1ns/1ps
module pcm_tx_serializer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0, en = 1'b0;
  logic [1:0] mode = 2'd0;
  logic rsv = 1'b0, sin = 1'b0, cinv = 1'b0, sinv = 1'b0;
  logic txclk = 1'b0, txsync = 1'b0;
  logic [7:0] byte_d = 8'h00;
  wire  tx_sync_w, tx_data_w;
  logic req, err;

  int total = 0, bad = 0;
  int slot, bitp, wr = 0, rd = 0, req_cnt = 0, err_cnt = 0;
  bit locked, prev_sync, done = 1'b0;
  logic [7:0] cur;
  logic [7:0] fifo [64];

  always #2.5 clk = ~clk;

  pcm_tx_serializer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .map_mode_i(mode), .rsv_ts24_i(rsv),
    .sync_in_mode_i(sin), .clk_inv_i(cinv), .sync_inv_i(sinv), .tx_clk_i(txclk),
    .tx_sync_i(txsync), .tx_sync_o(tx_sync_w), .tx_data_o(tx_data_w),
    .byte_req_o(req), .byte_i(byte_d), .sync_err_o(err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_pay(int m, bit r, int s);
    if (m == 0) return (s <= 22) || (s == 23 && !r);
    if (m == 1) return (s % 4 != 0) && !(r && s == 31);
    return !(s == 0 || s == 16);
  endfunction

  function automatic bit is_rsv(int m, bit r, int s);
    return r && ((m == 0 && s == 23) || (m == 1 && s == 31));
  endfunction

  // byte source and error counter
  initial forever begin
    logic [7:0] b;
    @(negedge clk);
    if (req === 1'b1) begin
      b = 8'($urandom);
      byte_d = b;
      fifo[wr % 64] = b;
      wr++;
      req_cnt++;
    end
    if (err === 1'b1) err_cnt++;
  end

  task automatic start_slot(input int s);
    if (exp_pay(int'(mode), rsv, s)) begin
      chk(rd != wr, "R4 byte requested before payload slot", wr - rd, 1);
      cur = (rd != wr) ? fifo[rd % 64] : 8'h00;
      if (rd != wr) rd++;
    end else begin
      cur = 8'hFF;
    end
  endtask

  task automatic model_reset();
    slot = 31; bitp = 0; locked = 1'b0; prev_sync = 1'b0; cur = 8'hFF; rd = wr;
  endtask

  // one bit period: active edge, model step, sync set at inactive edge, sample
  task automatic drive_bit(input bit unl_sync, input bit flip);
    bit exp_e, s_this, last;
    int e0;
    string tag;
    logic exp_d;
    @(negedge clk);
    txclk = ~cinv;
    exp_e = 1'b0;
    if (sin && !locked) begin
      if (prev_sync) begin
        locked = 1'b1; slot = 0; bitp = 0; start_slot(0);
      end
    end else begin
      exp_e = sin && (prev_sync != (slot == 31 && bitp == 7));
      if (bitp == 7) begin
        bitp = 0; slot = (slot + 1) % 32; start_slot(slot);
      end else bitp++;
    end
    e0 = err_cnt;
    last = (slot == 31 && bitp == 7);
    s_this = sin ? (locked ? (last ^ flip) : unl_sync) : 1'b0;
    repeat (4) @(negedge clk);
    txclk = cinv;
    txsync = s_this ^ sinv;
    prev_sync = s_this;
    repeat (3) @(negedge clk);
    exp_d = cur[7 - bitp];
    if (is_rsv(int'(mode), rsv, slot)) tag = "R3 reserved slot";
    else if (exp_pay(int'(mode), rsv, slot)) tag = "R1 payload bit";
    else tag = "R2 idle bit";
    if (cinv) tag = {tag, " R6 inverted clock"};
    chk(tx_data_w === exp_d, tag, int'(tx_data_w), int'(exp_d));
    if (!sin) chk(tx_sync_w === (last ^ sinv), "R5 sync output", int'(tx_sync_w), int'(last ^ sinv));
    else chk((err_cnt - e0) == int'(exp_e), "R7 sync error pulse", err_cnt - e0, int'(exp_e));
  endtask

  task automatic start_case(input int m, input bit r, input bit si, input bit ci, input bit syi);
    int c0;
    @(negedge clk);
    rst_n = 1'b0; en = 1'b0;
    mode = 2'(m); rsv = r; sin = si; cinv = ci; sinv = syi;
    txclk = ci; txsync = syi;
    repeat (3) @(negedge clk);
    model_reset();
    c0 = req_cnt;
    rst_n = 1'b1; en = 1'b1;
    repeat (4) @(negedge clk);
    chk(tx_data_w === 1'b1, "R2 data after reset", int'(tx_data_w), 1);
    chk((req_cnt - c0) == int'(exp_pay(m, r, 0)), "R4 startup request", req_cnt - c0, int'(exp_pay(m, r, 0)));
    if (!si) chk(tx_sync_w === syi, "R5 sync idle after reset", int'(tx_sync_w), int'(syi));
  endtask

  task automatic run_bits(input int n);
    for (int k = 0; k < n; k++) drive_bit(1'b0, 1'b0);
  endtask

  initial begin
    int c0, e0;
    void'($urandom(32'd1357));
    // directed map and polarity cases
    start_case(0, 1'b0, 1'b0, 1'b0, 1'b0); run_bits(600);
    start_case(0, 1'b1, 1'b0, 1'b1, 1'b0); run_bits(600);
    start_case(1, 1'b0, 1'b0, 1'b0, 1'b1); run_bits(600);
    start_case(1, 1'b1, 1'b0, 1'b1, 1'b1); run_bits(600);
    start_case(2, 1'b1, 1'b0, 1'b0, 1'b0); run_bits(600);
    // random configurations
    for (int n = 0; n < 3; n++) begin
      start_case(int'($urandom % 4), 1'($urandom), 1'b0, 1'($urandom), 1'($urandom));
      run_bits(520);
    end
    // input sync: lock, clean frames, early extra sync, missing sync (R7)
    start_case(0, 1'b1, 1'b1, 1'b0, 1'b1);
    run_bits(20);
    drive_bit(1'b1, 1'b0);
    run_bits(520);
    drive_bit(1'b0, 1'b1);
    for (int k = 0; k < 300 && !(slot == 31 && bitp == 6); k++) drive_bit(1'b0, 1'b0);
    drive_bit(1'b0, 1'b1);
    run_bits(100);
    // disable and restart (R8)
    start_case(0, 1'b0, 1'b0, 1'b0, 1'b0);
    run_bits(300);
    @(negedge clk);
    en = 1'b0;
    repeat (2) @(negedge clk);
    c0 = req_cnt; e0 = err_cnt;
    repeat (40) @(negedge clk);
    chk(req_cnt == c0, "R8 no request while disabled", req_cnt - c0, 0);
    chk(err_cnt == e0, "R8 no error while disabled", err_cnt - e0, 0);
    model_reset();
    en = 1'b1;
    repeat (4) @(negedge clk);
    chk((req_cnt - c0) == 1, "R8 restart request", req_cnt - c0, 1);
    chk(tx_data_w === 1'b1, "R8 idle data after restart", int'(tx_data_w), 1);
    run_bits(300);
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule